// File: doc/BRIEF.md
# Tapped Serial Shift Memory

This block is a serial memory made of a chain of one-bit flip-flop cells. A single data bit enters at the head of the chain. On every rising clock edge where the shift enable is high, all cells move one place together. When the enable is low, every cell keeps its value. A synchronous active-high reset clears the whole chain.

Two kinds of output are provided:

- **Taps.** The cells nearest the head appear on a small group of tap outputs. These pass through a shared output enable and float (high impedance) when it is low. A neighbouring block can therefore watch the most recent bits over a shared bus.
- **End of chain.** The last cell drives an output that is always active. It shows the bit that entered a full chain length of shifts earlier.

The chain length and the tap count are parameters, 64 and 4 by default. Tap k holds the bit that entered k+1 shifts ago.

Top module: `tapped_shift_mem`

## Requirements
- R1: A cycle with `rst` high clears every cell to 0. After such a cycle, `q_o` reads 0, and `tap_o` reads all zeros while `oe` is high.
- R2: On a rising edge with `rst` low and `shift_en` high, the head cell captures `ser_i`.
- R3: On a rising edge with `rst` low and `shift_en` low, no cell changes, so `q_o` and the driven taps keep their values.
- R4: Tap bit 0 of `tap_o` shows the `ser_i` value presented at the most recent shift. Tap bit k shows cell k, counted from the head.
- R5: After each shift, tap bit k (k >= 1) equals the value that tap bit k-1 held before that shift.
- R6: `q_o` equals the `ser_i` value presented DEPTH shifts earlier (64 by default), or 0 if fewer than DEPTH shifts have followed the last reset.
- R7: With `oe` high, `tap_o` drives the tap cell values. With `oe` low, every bit of `tap_o` is high impedance.
- R8: `q_o` does not depend on `oe`; it shows the last cell in both states of `oe`.
- R9: `rst` takes priority over `shift_en`: a cycle with both high leaves all cells at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every cell updates on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all cells |
| shift_en | input | 1 | Common shift enable for the whole chain |
| ser_i | input | 1 | Serial data bit entering the head cell |
| oe | input | 1 | Output enable for the tap outputs |
| tap_o | output | NTAPS | Head cells, high impedance when `oe` is low |
| q_o | output | 1 | Last cell of the chain, always driven |

## Verification
The bench builds the block with its default values: 64 cells and 4 taps. This is short enough that a random stream of a few hundred bits runs well past a full chain length. Values therefore reach `q_o` and are checked there, not just at the taps. It also covers the case where fewer than 64 shifts have passed since reset, where `q_o` must still read the cleared value. Four taps are enough to check the one-shift lag between each neighbouring pair. The bench also exercises held cycles, toggling of `oe`, and reset while shifting.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SHIFT = 2'd1,
    CELL_CLEAR = 2'd2
  } cell_op_e;

  function automatic cell_op_e decode_op(input logic clr, input logic adv);
    if (clr)      return CELL_CLEAR;
    else if (adv) return CELL_SHIFT;
    else          return CELL_HOLD;
  endfunction
endpackage

// File: rtl/tss_bit_cell.sv
module tss_bit_cell
  import tss_pkg::*;
(
  input  logic     clk,
  input  cell_op_e op,
  input  logic     d,
  output logic     q
);
  always_ff @(posedge clk) begin
    case (op)
      CELL_CLEAR: q <= 1'b0;
      CELL_SHIFT: q <= d;
      default:    q <= q;
    endcase
  end
endmodule

// File: rtl/tss_shift_chain.sv
module tss_shift_chain
  import tss_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_i,
  output logic [DEPTH-1:0] stages
);
  cell_op_e         op;
  logic [DEPTH-1:0] feed;

  assign op = decode_op(rst, shift_en);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      if (g == 0) begin : g_head
        assign feed[g] = ser_i;
      end else begin : g_body
        assign feed[g] = stages[g-1];
      end
      tss_bit_cell u_cell (
        .clk (clk),
        .op  (op),
        .d   (feed[g]),
        .q   (stages[g])
      );
    end
  endgenerate
endmodule

// File: rtl/tss_tap_driver.sv
module tss_tap_driver #(
  parameter int NTAPS = 4
) (
  input  logic             oe,
  input  logic [NTAPS-1:0] val,
  output wire  [NTAPS-1:0] pins
);
  genvar g;
  generate
    for (g = 0; g < NTAPS; g++) begin : g_tap
      assign pins[g] = oe ? val[g] : 1'bz;
    end
  endgenerate
endmodule

// File: rtl/tapped_shift_mem.sv
module tapped_shift_mem #(
  parameter int DEPTH = 64,
  parameter int NTAPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_i,
  input  logic             oe,
  output wire  [NTAPS-1:0] tap_o,
  output logic             q_o
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stages;

  tss_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .ser_i    (ser_i),
    .stages   (stages)
  );

  tss_tap_driver #(.NTAPS(NTAPS)) u_taps (
    .oe   (oe),
    .val  (stages[NTAPS-1:0]),
    .pins (tap_o)
  );

  assign q_o = stages[LAST];
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int DEPTH = 64,
  parameter int NTAPS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic             ser_i,
  input logic             oe,
  input logic [DEPTH-1:0] stages,
  input logic [NTAPS-1:0] tap_o,
  input logic             q_o
);
  AST_CLEAR_ON_RESET: assert property (@(posedge clk) rst |=> (q_o == 1'b0 && stages == '0)); // R1
  AST_RESET_WINS: assert property (@(posedge clk) (rst && shift_en) |=> stages[0] == 1'b0); // R9
  AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (rst) (shift_en && !rst) |=> stages[0] == $past(ser_i)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (!shift_en && !rst) |=> $stable(stages)); // R3
  AST_END_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (shift_en && !rst) |=> q_o == $past(stages[DEPTH-2])); // R6
  AST_TAPS_DRIVEN: assert property (@(posedge clk) disable iff (rst) oe |-> tap_o == stages[NTAPS-1:0]); // R7

  genvar g;
  generate
    for (g = 1; g < NTAPS; g++) begin : g_lag
      AST_TAP_LAG: assert property (@(posedge clk) disable iff (rst) (shift_en && !rst) |=> stages[g] == $past(stages[g-1])); // R5
    end
  endgenerate
endmodule

bind tapped_shift_mem tss_checker #(.DEPTH(DEPTH), .NTAPS(NTAPS)) u_tss_checker (
  .clk      (clk),
  .rst      (rst),
  .shift_en (shift_en),
  .ser_i    (ser_i),
  .oe       (oe),
  .stages   (stages),
  .tap_o    (tap_o),
  .q_o      (q_o)
);

// File: tb/test_tapped_shift_mem.sv
`timescale 1ns/1ps
module test_tapped_shift_mem;
  localparam int DEPTH = 64;
  localparam int NTAPS = 4;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic shift_en = 1'b0;
  logic ser_i = 1'b0;
  logic oe = 1'b0;
  wire  [NTAPS-1:0] tap_o;
  logic q_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mdl[$];

  always #4 clk = ~clk;

  tapped_shift_mem #(.DEPTH(DEPTH), .NTAPS(NTAPS)) i_tapped_shift_mem (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_i(ser_i),
    .oe(oe), .tap_o(tap_o), .q_o(q_o)
  );

  task automatic chk(input string req, input logic [NTAPS-1:0] act, input logic [NTAPS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [NTAPS-1:0] mdl_taps();
    logic [NTAPS-1:0] v;
    for (int k = 0; k < NTAPS; k++) v[k] = mdl[k];
    return v;
  endfunction

  // One clock: drive, update reference, check at the following falling edge.
  task automatic step(input logic r, input logic en, input logic d, input logic o);
    logic [NTAPS-1:0] exp_t;
    rst = r; shift_en = en; ser_i = d; oe = o;
    @(posedge clk);
    if (r) begin
      foreach (mdl[i]) mdl[i] = 1'b0;
    end else if (en) begin
      mdl.push_front(d);
      void'(mdl.pop_back());
    end
    @(negedge clk);
    chk(o ? "R6" : "R8", {{(NTAPS-1){1'b0}}, q_o}, {{(NTAPS-1){1'b0}}, mdl[DEPTH-1]});
    exp_t = mdl_taps();
    if (o) begin
      chk("R4", tap_o, exp_t);
    end else begin
      // R7: a floating tap must not read as a driven 1
      for (int k = 0; k < NTAPS; k++)
        if (exp_t[k]) chk("R7", {{(NTAPS-1){1'b0}}, tap_o[k] === 1'b1}, '0);
    end
  endtask

  initial begin
    #(8ns * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NTAPS-1:0] prev;
    logic [NTAPS-1:0] held;
    logic             held_q;
    for (int i = 0; i < DEPTH; i++) mdl.push_back(1'b0);
    @(negedge clk);
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    chk("R1", tap_o, '0);
    chk("R1", {{(NTAPS-1){1'b0}}, q_o}, '0);

    // R2 / R5: known pattern with output enabled
    for (int i = 0; i < 8; i++) begin
      prev = tap_o;
      step(0, 1, i[0] ^ i[1], 1);
      chk("R2", {{(NTAPS-1){1'b0}}, tap_o[0]}, {{(NTAPS-1){1'b0}}, 1'(i[0] ^ i[1])});
      for (int k = 1; k < NTAPS; k++)
        chk("R5", {{(NTAPS-1){1'b0}}, tap_o[k]}, {{(NTAPS-1){1'b0}}, prev[k-1]});
    end

    // R6: before a full chain of shifts q_o still reads the cleared value
    chk("R6", {{(NTAPS-1){1'b0}}, q_o}, '0);

    // Random stream with enable gaps and oe toggling
    for (int i = 0; i < 400; i++) begin
      step(0, ($urandom % 4) != 0, 1'($urandom), ($urandom % 3) != 0);
    end

    // R3: hold with enable low, outputs unchanged
    step(0, 1, 1, 1);
    held = tap_o; held_q = q_o;
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1'(i), 1);
      chk("R3", tap_o, held);
      chk("R3", {{(NTAPS-1){1'b0}}, q_o}, {{(NTAPS-1){1'b0}}, held_q});
    end

    // R6: a full chain of ones, then check q_o reaches 1 exactly at DEPTH
    step(1, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 1, 1, 1);
    chk("R6", {{(NTAPS-1){1'b0}}, q_o}, {{(NTAPS-1){1'b0}}, 1'b1});

    // R8: q_o unchanged by oe alone
    held_q = q_o;
    step(0, 0, 0, 0);
    chk("R8", {{(NTAPS-1){1'b0}}, q_o}, {{(NTAPS-1){1'b0}}, held_q});
    // R7: all taps are 1 in the model, none may read as a driven 1
    chk("R7", {{(NTAPS-1){1'b0}}, tap_o[0] === 1'b1}, '0);

    // R9: reset while shifting ones clears everything
    step(1, 1, 1, 1);
    chk("R9", tap_o, '0);
    chk("R9", {{(NTAPS-1){1'b0}}, q_o}, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule